// File: doc/BRIEF.md
# Windowed Pulse Integration Channel

This block turns the free-running sample stream of one digitizer channel into one energy figure per detected pulse. A sample arrives on every clock. While the channel is idle, a running average of the input follows the quiescent level. A discriminator hit opens a window. For every sample in that window, the current average is subtracted and the difference is added to a signed accumulator. When the window closes, the block presents the area together with a one-cycle valid strobe.

The window length is a run-time setting counted in sample periods. It may be as short as a single sample. A setting of zero selects an open-ended window, which only an external stop pulse closes. Because the settings are taken at well-defined moments, software may rewrite them at any time. A second hit inside an open window does not restart the window; it marks the result as piled up. After each result the channel stays busy for a programmable number of samples before it accepts a new hit.

Top module: `pulse_area_integrator`

## Requirements
- R1: While reset is held and on release, `res_valid`, `busy` and `res_pile` are 0, `res_sum` is 0 and the baseline is 0.
- R2: A hit seen while idle opens a window whose first sample is the one present in the hit cycle. With a window length N of 1 to 255, the window takes N consecutive samples. `res_valid` is high in the cycle after the last sample, and `busy` is high from the cycle after the hit until the channel re-arms.
- R3: The baseline is the top 10 bits of a 14-bit register B, which starts at 0. On each idle cycle without a hit, B is updated as B + sample - (B >> 4). Each sample in a window contributes sample minus baseline as a signed value.
- R4: The baseline does not change in the cycle that opens a window, nor in any cycle while `busy` is high.
- R5: A window length of 0 selects open-ended mode. In that mode the window ends on the first cycle with `stop` high, and the sample of that cycle is included. `stop` has no effect in finite mode and has no effect while idle.
- R6: In open-ended mode the sum saturates at +262143 and at -262144 rather than wrapping.
- R7: The result is 19 bits signed, so a finite 255-sample window of full-scale samples over a zero baseline gives the exact value 260865.
- R8: A hit during an open window neither restarts nor lengthens it. It sets `res_pile` in that window's result, and the next window starts with the flag clear.
- R9: After a result the channel stays busy for `dead_len` cycles and ignores hits during that time. A `dead_len` of 0 re-arms it in the cycle right after the last sample.
- R10: `win_len` is taken in the cycle that opens a window and `dead_len` in the cycle of the window's last sample, so later changes do not affect that window or that dead period.
- R11: `res_valid` is high for exactly one cycle per completed window and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| sample | input | 10 | Unsigned digitizer sample |
| hit | input | 1 | Discriminator hit for this channel |
| stop | input | 1 | Ends an open-ended window |
| win_len | input | 8 | Window length in samples, 0 = open-ended |
| dead_len | input | 8 | Busy samples after each result |
| res_valid | output | 1 | One-cycle result strobe |
| res_sum | output | 19 | Signed baseline-corrected area |
| res_pile | output | 1 | Second hit seen inside the window |
| busy | output | 1 | Window open or dead time running |

## Verification
On every cycle the assertions check four things. The result strobe follows exactly the cycle that closes a window. The baseline is frozen while the channel is busy or opening a window. An open-ended window never closes without `stop`. Any sample that does not close a window leaves the channel busy.

The arithmetic cannot be shown by a property and needs the bench's scenarios. This covers the baseline average, the per-sample subtraction, saturation at both rails and the exact finite-width sum. The same holds for pile-up marking, mid-window rewrites of the settings, and hits dropped during dead time.

// File: rtl/pai_pkg.sv
package pai_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WIN  = 2'd1,
    ST_DEAD = 2'd2
  } pai_state_e;

  // Sign bit + sample magnitude + growth for the longest finite window.
  function automatic int acc_width(int sample_w, int len_w);
    return sample_w + 1 + len_w;
  endfunction

endpackage

// File: rtl/pai_baseline.sv
module pai_baseline #(
  parameter int SAMPLE_W = 10,
  parameter int BL_SHIFT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                upd_en,
  input  logic [SAMPLE_W-1:0] sample,
  output logic [SAMPLE_W-1:0] base
);
  localparam int FW = SAMPLE_W + BL_SHIFT;

  logic [FW-1:0] bl_q;

  // Exponential average: add the new sample, remove one averaged sample.
  function automatic logic [FW-1:0] bl_next(logic [FW-1:0] cur,
                                            logic [SAMPLE_W-1:0] s);
    logic [FW-1:0] drop;
    drop = cur >> BL_SHIFT;
    return cur + FW'(s) - drop;
  endfunction

  assign base = bl_q[FW-1:BL_SHIFT];

  always_ff @(posedge clk) begin
    if (!rst_n)      bl_q <= '0;
    else if (upd_en) bl_q <= bl_next(bl_q, sample);
  end

endmodule

// File: rtl/pai_window_ctrl.sv
module pai_window_ctrl
  import pai_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int DEAD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic              stop,
  input  logic [LEN_W-1:0]  win_len,
  input  logic [DEAD_W-1:0] dead_len,
  output logic              start_evt,
  output logic              in_win,
  output logic              last_evt,
  output logic              pile_evt,
  output logic              open_eff,
  output logic              busy,
  output logic              bl_upd
);
  pai_state_e        state_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  len_q;
  logic              open_q;
  logic [DEAD_W-1:0] dcnt_q;

  logic [LEN_W-1:0]  len_eff;
  logic [LEN_W-1:0]  cnt_eff;
  logic [LEN_W:0]    taken;
  logic              idle;

  function automatic logic window_done(logic open_m, logic stp,
                                       logic [LEN_W:0] n_taken,
                                       logic [LEN_W-1:0] n_len);
    if (open_m) return stp;
    return n_taken == {1'b0, n_len};
  endfunction

  always_comb begin
    idle      = (state_q == ST_IDLE);
    start_evt = idle & hit;
    in_win    = start_evt | (state_q == ST_WIN);
    pile_evt  = (state_q == ST_WIN) & hit;
    len_eff   = start_evt ? win_len : len_q;
    open_eff  = start_evt ? (win_len == '0) : open_q;
    cnt_eff   = start_evt ? '0 : cnt_q;
    taken     = {1'b0, cnt_eff} + (LEN_W+1)'(1);
    last_evt  = in_win & window_done(open_eff, stop, taken, len_eff);
    busy      = !idle;
    bl_upd    = idle & !hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      len_q   <= '0;
      open_q  <= 1'b0;
      dcnt_q  <= '0;
    end else begin
      if (start_evt) begin
        len_q  <= win_len;
        open_q <= (win_len == '0);
      end
      if (in_win) begin
        cnt_q <= taken[LEN_W-1:0];
        if (last_evt) begin
          if (dead_len == '0) begin
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_DEAD;
            dcnt_q  <= dead_len;
          end
        end else begin
          state_q <= ST_WIN;
        end
      end else if (state_q == ST_DEAD) begin
        if (dcnt_q == DEAD_W'(1)) state_q <= ST_IDLE;
        else                      dcnt_q  <= dcnt_q - DEAD_W'(1);
      end
    end
  end

endmodule

// File: rtl/pai_accum.sv
module pai_accum #(
  parameter int SAMPLE_W = 10,
  parameter int ACC_W    = 19
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SAMPLE_W-1:0]     sample,
  input  logic [SAMPLE_W-1:0]     base,
  input  logic                    in_win,
  input  logic                    start_evt,
  input  logic                    last_evt,
  input  logic                    open_eff,
  input  logic                    pile_evt,
  output logic                    res_valid,
  output logic signed [ACC_W-1:0] res_sum,
  output logic                    res_pile
);
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [ACC_W-1:0]  acc_q;
  logic                     pile_q;
  logic signed [SAMPLE_W:0] diff;
  logic signed [ACC_W-1:0]  acc_base;
  logic signed [ACC_W-1:0]  acc_nxt;
  logic                     pile_nxt;

  // One extra bit catches overflow; clip to the rails only when asked.
  function automatic logic signed [ACC_W-1:0] add_clip(
      logic signed [ACC_W-1:0] a, logic signed [SAMPLE_W:0] d, logic clip);
    logic [ACC_W:0] w;
    w = {a[ACC_W-1], a} + {{(ACC_W-SAMPLE_W){d[SAMPLE_W]}}, d};
    if (clip && (w[ACC_W] != w[ACC_W-1]))
      return w[ACC_W] ? ACC_MIN : ACC_MAX;
    return w[ACC_W-1:0];
  endfunction

  always_comb begin
    diff     = $signed({1'b0, sample}) - $signed({1'b0, base});
    acc_base = start_evt ? '0 : acc_q;
    acc_nxt  = add_clip(acc_base, diff, open_eff);
    pile_nxt = start_evt ? 1'b0 : (pile_q | pile_evt);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q     <= '0;
      pile_q    <= 1'b0;
      res_valid <= 1'b0;
      res_sum   <= '0;
      res_pile  <= 1'b0;
    end else begin
      res_valid <= last_evt;
      if (in_win) begin
        acc_q  <= acc_nxt;
        pile_q <= pile_nxt;
      end
      if (last_evt) begin
        res_sum  <= acc_nxt;
        res_pile <= pile_nxt;
      end
    end
  end

endmodule

// File: rtl/pulse_area_integrator.sv
module pulse_area_integrator #(
  parameter  int SAMPLE_W = 10,
  parameter  int LEN_W    = 8,
  parameter  int DEAD_W   = 8,
  parameter  int BL_SHIFT = 4,
  localparam int ACC_W    = pai_pkg::acc_width(SAMPLE_W, LEN_W)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SAMPLE_W-1:0]     sample,
  input  logic                    hit,
  input  logic                    stop,
  input  logic [LEN_W-1:0]        win_len,
  input  logic [DEAD_W-1:0]       dead_len,
  output logic                    res_valid,
  output logic signed [ACC_W-1:0] res_sum,
  output logic                    res_pile,
  output logic                    busy
);
  logic [SAMPLE_W-1:0] base_w;
  logic start_evt, in_win, last_evt, pile_evt, open_eff, bl_upd;

  pai_baseline #(.SAMPLE_W(SAMPLE_W), .BL_SHIFT(BL_SHIFT)) u_base (
    .clk(clk), .rst_n(rst_n), .upd_en(bl_upd), .sample(sample), .base(base_w)
  );

  pai_window_ctrl #(.LEN_W(LEN_W), .DEAD_W(DEAD_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .hit(hit), .stop(stop),
    .win_len(win_len), .dead_len(dead_len),
    .start_evt(start_evt), .in_win(in_win), .last_evt(last_evt),
    .pile_evt(pile_evt), .open_eff(open_eff), .busy(busy), .bl_upd(bl_upd)
  );

  pai_accum #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .sample(sample), .base(base_w),
    .in_win(in_win), .start_evt(start_evt), .last_evt(last_evt),
    .open_eff(open_eff), .pile_evt(pile_evt),
    .res_valid(res_valid), .res_sum(res_sum), .res_pile(res_pile)
  );

endmodule

// File: rtl/pai_checker.sv
module pai_checker #(
  parameter int SAMPLE_W = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic                stop,
  input logic                busy,
  input logic                res_valid,
  input logic                start_evt,
  input logic                in_win,
  input logic                last_evt,
  input logic                open_eff,
  input logic [SAMPLE_W-1:0] baseline
);

  // R11
  valid_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_evt |=> res_valid);

  // R11
  no_stray_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last_evt |=> !res_valid);

  // R4
  baseline_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || start_evt) |=> $stable(baseline));

  // R5
  open_needs_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && open_eff && !stop) |-> !last_evt);

  // R2
  window_stays_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && !last_evt) |=> busy);

endmodule

bind pulse_area_integrator pai_checker #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .stop(stop), .busy(busy), .res_valid(res_valid),
  .start_evt(start_evt), .in_win(in_win), .last_evt(last_evt),
  .open_eff(open_eff), .baseline(base_w)
);

// File: tb/pulse_area_integrator_test.sv
module pulse_area_integrator_test;
  localparam int SW    = 10;
  localparam int LW    = 8;
  localparam int DW    = 8;
  localparam int ACC_W = SW + 1 + LW;
  localparam int SMAX  = (1 << (ACC_W-1)) - 1;
  localparam int SMIN  = -(1 << (ACC_W-1));

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SW-1:0] sample = '0;
  logic hit = 1'b0;
  logic stop = 1'b0;
  logic [LW-1:0] win_len = '0;
  logic [DW-1:0] dead_len = '0;
  logic res_valid;
  logic signed [ACC_W-1:0] res_sum;
  logic res_pile;
  logic busy;

  always #10 clk = ~clk;

  pulse_area_integrator uut (
    .clk(clk), .rst_n(rst_n), .sample(sample), .hit(hit), .stop(stop),
    .win_len(win_len), .dead_len(dead_len), .res_valid(res_valid),
    .res_sum(res_sum), .res_pile(res_pile), .busy(busy)
  );

  int checks = 0;
  int errors = 0;

  // Reference state: phase 0 idle, 1 window, 2 dead.
  int m_bl = 0, m_ph = 0, m_taken = 0, m_len = 0, m_acc = 0, m_dead = 0;
  bit m_open = 0, m_pile = 0;
  bit e_valid = 0, e_pile = 0;
  int e_sum = 0;

  function automatic int rail(int v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic ref_step(int s, bit h, bit st, int wl, int dl);
    int avg;
    bit take;
    avg = m_bl / 16;
    take = 0;
    e_valid = 0;
    if (m_ph == 0) begin
      if (h) begin
        take = 1; m_len = wl; m_open = (wl == 0);
        m_acc = 0; m_pile = 0; m_taken = 0;
      end else begin
        m_bl = m_bl + s - avg;
      end
    end else if (m_ph == 1) begin
      take = 1;
      if (h) m_pile = 1;
    end else begin
      if (m_dead == 1) m_ph = 0;
      else m_dead = m_dead - 1;
    end
    if (take) begin
      m_acc = m_acc + (s - avg);
      if (m_open) m_acc = rail(m_acc);
      m_taken++;
      if (m_open ? st : (m_taken == m_len)) begin
        e_valid = 1; e_sum = m_acc; e_pile = m_pile;
        if (dl == 0) m_ph = 0;
        else begin m_ph = 2; m_dead = dl; end
      end else begin
        m_ph = 1;
      end
    end
  endtask

  task automatic tick(int s, bit h, bit st, string tag);
    sample = SW'(s); hit = h; stop = st;
    ref_step(s, h, st, int'(win_len), int'(dead_len));
    @(posedge clk);
    @(negedge clk);
    check("R11", int'(res_valid), int'(e_valid), "valid strobe");
    check("R9", int'(busy), int'(m_ph != 0), "busy");
    if (e_valid) begin
      check(tag, int'(res_sum), e_sum, "area");
      check("R8", int'(res_pile), int'(e_pile), "pile flag");
    end
  endtask

  task automatic quiet(int n, int s);
    for (int i = 0; i < n; i++) tick(s, 1'b0, 1'b0, "R3");
  endtask

  task automatic pulse(int n, int s, string tag);
    tick(s, 1'b1, 1'b0, tag);
    for (int i = 1; i < n; i++) tick(s, 1'b0, 1'b0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int seed_tmp;
    seed_tmp = $urandom(1357);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", int'(res_valid), 0, "reset valid");
    check("R1", int'(busy), 0, "reset busy");
    check("R1", int'(res_sum), 0, "reset sum");
    check("R1", int'(res_pile), 0, "reset pile");
    rst_n = 1'b1;

    // R2 basic finite window over a zero baseline
    win_len = 8'd4; dead_len = 8'd0;
    quiet(3, 0);
    pulse(4, 100, "R2");
    check("R2", int'(res_sum), 400, "four samples of 100");

    // R3 one idle sample of 160 gives baseline 10
    quiet(1, 160);
    win_len = 8'd1;
    tick(10, 1'b1, 1'b0, "R3");
    check("R3", int'(res_valid), 1, "single-sample window");
    check("R3", int'(res_sum), 0, "sample equal to baseline");

    // R4 / R9 baseline frozen, hits dropped during dead time
    win_len = 8'd2; dead_len = 8'd5;
    pulse(2, 500, "R4");
    check("R4", int'(res_sum), 980, "baseline held at 10");
    for (int i = 0; i < 5; i++) tick(700, 1'b1, 1'b0, "R9");
    check("R9", int'(busy), 0, "re-armed after dead time");
    dead_len = 8'd0;
    pulse(2, 10, "R9");
    check("R9", int'(res_sum), 0, "dead-time hits ignored, baseline kept");

    // R8 pile-up does not restart window
    win_len = 8'd6;
    tick(20, 1'b1, 1'b0, "R8");
    tick(20, 1'b0, 1'b0, "R8");
    tick(20, 1'b1, 1'b0, "R8");
    for (int i = 0; i < 3; i++) tick(20, 1'b0, 1'b0, "R8");
    check("R8", int'(res_valid), 1, "window kept six samples");
    check("R8", int'(res_sum), 60, "piled window area");
    check("R8", int'(res_pile), 1, "pile flag set");
    pulse(6, 20, "R8");
    check("R8", int'(res_pile), 0, "pile flag cleared");

    // R5 stop ignored in finite mode and while idle; ends open window
    win_len = 8'd3;
    tick(30, 1'b1, 1'b0, "R5");
    tick(30, 1'b0, 1'b1, "R5");
    check("R5", int'(res_valid), 0, "stop ignored in finite window");
    tick(30, 1'b0, 1'b0, "R5");
    check("R5", int'(res_sum), 60, "finite window full length");
    tick(10, 1'b0, 1'b1, "R5");
    check("R5", int'(res_valid), 0, "stop ignored while idle");
    win_len = 8'd0;
    pulse(5, 40, "R5");
    tick(40, 1'b0, 1'b1, "R5");
    check("R5", int'(res_sum), 180, "open window closed by stop");

    // R10 mid-window rewrite of length has no effect
    win_len = 8'd3;
    tick(50, 1'b1, 1'b0, "R10");
    win_len = 8'd7;
    tick(50, 1'b0, 1'b0, "R10");
    tick(50, 1'b0, 1'b0, "R10");
    check("R10", int'(res_valid), 1, "length taken at start");
    check("R10", int'(res_sum), 120, "three samples of 40 above baseline");

    // R7 longest finite window at full scale
    quiet(120, 0);
    win_len = 8'd255;
    pulse(255, 1023, "R7");
    check("R7", int'(res_sum), 260865, "exact full-scale area");

    // R6 saturation at both rails in open mode
    win_len = 8'd0;
    pulse(300, 1023, "R6");
    tick(1023, 1'b0, 1'b1, "R6");
    check("R6", int'(res_sum), SMAX, "positive rail");
    quiet(300, 1023);
    pulse(300, 0, "R6");
    tick(0, 1'b0, 1'b1, "R6");
    check("R6", int'(res_sum), SMIN, "negative rail");

    // Random traffic mixing all modes
    quiet(60, 0);
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 40 == 0) begin
        case ($urandom % 5)
          0: win_len = 8'd0;
          1: win_len = 8'd1;
          2: win_len = 8'd2;
          3: win_len = LW'($urandom % 32);
          default: win_len = 8'd255;
        endcase
        dead_len = DW'($urandom % 4);
      end
      tick(int'($urandom % 1024), ($urandom % 6) == 0, ($urandom % 10) == 0, "R2");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule